// File: doc/BRIEF.md
# MDIO Station-Management Master

This block runs register reads and writes against external PHY devices over the two-wire management bus. A request names the direction, a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block derives the management clock from the system clock through a programmable divider. It shifts a complete frame onto the data line, which it drives through a separate output enable so that a pad can tri-state it. For a read it releases the line and collects the 16 bits the PHY returns.

Requests arrive on a valid/ready handshake. `req_ready` is high exactly when no frame is in flight. A request is taken on a system clock edge where `req_valid` and `req_ready` are both high. While a frame runs, `req_ready` stays low, and anything presented on the request pins has no effect. Completion is signalled by a one-cycle `done`. For reads, `rd_valid` pulses in the same cycle, and `rd_data` then holds the word until the next read completes. The result side has no back-pressure.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset and whenever no frame is in flight: `mdc` is low, `mdio_oe` is low, `busy` is low and `req_ready` is high.
- R2: During a frame, `mdc` has a period of 2*D system clocks, where D is `clk_div`, or 1 when `clk_div` is 0. Each frame has exactly 64 rising edges of `mdc`.
- R3: The first 32 bits of every frame are ones, driven with `mdio_oe` high.
- R4: After the preamble come the start bits 0 then 1, followed by the opcode: 0,1 for a write and 1,0 for a read.
- R5: After the opcode, the PHY address and then the register address are sent, 5 bits each, most significant bit first.
- R6: In a write frame, bits 46 and 47 are 1 then 0, and bits 48..63 carry `req_wdata` from bit 15 down to bit 0. `mdio_oe` is high for all 64 bits.
- R7: In a read frame, `mdio_oe` is low for bits 46..63. The bits the PHY presents at bits 48..63, sampled on rising `mdc`, form `rd_data` with the first one as bit 15.
- R8: `mdio_o` changes only together with a falling edge of `mdc`, apart from the cycle that starts a frame. The line is therefore stable at every rising edge.
- R9: A request is accepted only when `req_ready` is high, and `busy` is high on the next cycle. A request presented while busy is ignored: it neither alters the frame in flight nor starts another one.
- R10: `done` is a single-cycle pulse after the last bit, and `busy` is low in that cycle. `rd_valid` pulses with `done` for reads only.
- R11: `rd_data` changes only in a cycle where `rd_valid` is high. Write frames leave it unchanged.
- R12: After a frame ends, `mdio_oe` returns low and `mdc` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W (4) | Half-period of `mdc` in system clocks; 0 acts as 1 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Frame in flight |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_valid | output | 1 | One-cycle pulse: new `rd_data` |
| rd_data | output | 16 | Last word read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A table of frames varies the direction, the address fields (all ones, all zeros, alternating patterns) and the divider, including 0. Each frame's bits, recorded on rising `mdc`, are compared against the expected field layout. These patterns separate a swapped opcode, swapped addresses or a reversed bit order, and the measured `mdc` period exposes divider off-by-one errors. Reads return PHY words with distinct first and last bits, which shows the sample edge and the capture order. Directed tests cover the reset state, a request intruding on a busy frame, and a write that follows a read, which must keep `rd_data`.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PHY_W    = 5;
  localparam int REG_W    = 5;
  localparam int DATA_W   = 16;
  localparam int PRE_BITS = 32;
  // start(2) + opcode(2) + addresses + turnaround(2) + data
  localparam int FRAME_BITS  = PRE_BITS + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int RELEASE_IDX = PRE_BITS + 4 + PHY_W + REG_W;
  localparam int DATA_IDX    = RELEASE_IDX + 2;
  localparam int CNT_W       = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } mdio_op_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             half_end;

  assign lim       = (div == '0) ? DIV_W'(1) : div;
  assign half_end  = (cnt >= lim - 1'b1);
  assign rise_tick = run && half_end && !mdc;
  assign fall_tick = run && half_end && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (half_end) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [PHY_W-1:0]  phy,
  input  logic [REG_W-1:0]  regad,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fall_tick,
  output logic              busy,
  output logic              is_wr,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              frame_end,
  output logic              sample_en
);
  localparam logic [CNT_W-1:0] LAST_IX = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] REL_IX  = CNT_W'(RELEASE_IDX);
  localparam logic [CNT_W-1:0] DAT_IX  = CNT_W'(DATA_IDX);

  logic [FRAME_BITS-1:0] shreg;
  logic [FRAME_BITS-1:0] frame_w;
  logic [CNT_W-1:0]      bitcnt;
  logic [CNT_W-1:0]      nxt;
  mdio_op_e              op;

  assign op      = start_write ? OP_WRITE : OP_READ;
  assign frame_w = {{PRE_BITS{1'b1}}, 2'b01, op, phy, regad,
                    (start_write ? 2'b10 : 2'b11),
                    (start_write ? wdata : {DATA_W{1'b1}})};
  assign nxt       = bitcnt + 1'b1;
  assign frame_end = busy && fall_tick && (bitcnt == LAST_IX);
  assign sample_en = busy && !is_wr && (bitcnt >= DAT_IX);
  assign mdio_o    = shreg[FRAME_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bitcnt  <= '0;
      busy    <= 1'b0;
      is_wr   <= 1'b0;
      mdio_oe <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        shreg   <= frame_w;
        bitcnt  <= '0;
        busy    <= 1'b1;
        is_wr   <= start_write;
        mdio_oe <= 1'b1;
      end else if (frame_end) begin
        busy    <= 1'b0;
        mdio_oe <= 1'b0;
        done    <= 1'b1;
      end else if (busy && fall_tick) begin
        shreg   <= {shreg[FRAME_BITS-2:0], 1'b0};
        bitcnt  <= nxt;
        mdio_oe <= is_wr || (nxt < REL_IX);
      end
    end
  end
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_tick,
  input  logic              sample_en,
  input  logic              mdio_i,
  input  logic              commit,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] shift_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= commit;
      if (rise_tick && sample_en) shift_q <= {shift_q[DATA_W-2:0], mdio_i};
      if (commit) rd_data <= shift_q;
    end
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  clk_div,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic rise_tick, fall_tick, frame_end, sample_en, is_wr, accept;

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;

  mdio_clk_gen #(.DIV_W(DIV_W)) clk_gen_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .div       (clk_div),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (accept),
    .start_write (req_write),
    .phy         (req_phy),
    .regad       (req_reg),
    .wdata       (req_wdata),
    .fall_tick   (fall_tick),
    .busy        (busy),
    .is_wr       (is_wr),
    .mdio_o      (mdio_o),
    .mdio_oe     (mdio_oe),
    .done        (done),
    .frame_end   (frame_end),
    .sample_en   (sample_en)
  );

  mdio_rx_capture cap_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_tick (rise_tick),
    .sample_en (sample_en),
    .mdio_i    (mdio_i),
    .commit    (frame_end && !is_wr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_master_chk.sv
module mdio_mgmt_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        done,
  input logic        rd_valid,
  input logic [15:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  // R1 / R12: quiet bus outside a frame
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mdc && !mdio_oe));

  // R8: data changes only with the falling clock edge
  p_drive_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$stable(mdio_o)) |-> $fell(mdc));

  // R9: an accepted request starts a frame
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);

  // R10: single-cycle done, bus already free
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_rdv_with_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> done);

  // R11: read word held between completions
  p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

bind mdio_mgmt_master mdio_mgmt_master_chk chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe)
);

// File: tb/mdio_mgmt_master_tb_top.sv
module mdio_mgmt_master_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  clk_div = 4'd1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_phy = '0;
  logic [4:0]  req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        busy, done, rd_valid, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic        mdio_i = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // bench-side bus monitor and PHY model
  int          rise_k = 0;
  int          rise_cyc0 = 0, rise_cyc1 = 0;
  int          r8_bad = 0;
  logic        last_fall_o = 1'b1;
  logic [63:0] cap_o, cap_oe;
  logic [15:0] phy_data = '0;
  logic [15:0] last_rd = '0;

  // [30] write, [29:25] phy, [24:20] reg, [19:4] data, [3:0] divider
  localparam logic [30:0] VEC [6] = '{
    {1'b1, 5'h1F, 5'h00, 16'hA5C3, 4'd1},
    {1'b0, 5'h01, 5'h1F, 16'h8001, 4'd2},
    {1'b1, 5'h15, 5'h0A, 16'hFFFF, 4'd3},
    {1'b0, 5'h0A, 5'h15, 16'h5A3C, 4'd1},
    {1'b1, 5'h00, 5'h00, 16'h0000, 4'd4},
    {1'b0, 5'h1F, 5'h1F, 16'h7E81, 4'd0}
  };

  mdio_mgmt_master dut_i (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge mdc) begin
    #1;
    if (rise_k < 64) begin
      cap_o[63-rise_k]  = mdio_o;
      cap_oe[63-rise_k] = mdio_oe;
    end
    if (mdio_oe && mdio_o !== last_fall_o) r8_bad++;
    if (rise_k == 0) rise_cyc0 = cyc;
    if (rise_k == 1) rise_cyc1 = cyc;
    rise_k++;
  end

  always @(negedge mdc) begin
    mdio_i <= (rise_k >= 48 && rise_k < 64) ? phy_data[63-rise_k] : 1'b1;
    #1;
    last_fall_o = mdio_o;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic wr, input logic [4:0] phy,
                         input logic [4:0] rg, input logic [15:0] data,
                         input logic [3:0] div, input bit poke);
    logic [63:0] exp_f, exp_oe;
    int eff, waited;
    eff    = (div == 0) ? 1 : int'(div);
    exp_f  = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, rg,
              (wr ? 2'b10 : 2'b11), (wr ? data : 16'hFFFF)};
    exp_oe = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
    @(negedge clk);
    clk_div = div; phy_data = data; rise_k = 0; r8_bad = 0; last_fall_o = 1'b1;
    cap_o = '0; cap_oe = '0;
    req_write = wr; req_phy = phy; req_reg = rg;
    req_wdata = wr ? data : 16'h0;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready when idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R9 busy after accept", 64'(busy), 64'd1);
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(req_ready == 1'b0, "R9 not ready while busy", 64'(req_ready), 64'd0);
      req_valid = 1'b1; req_write = ~wr; req_phy = ~phy; req_reg = ~rg;
      req_wdata = ~data;
      @(negedge clk);
      req_valid = 1'b0;
    end
    waited = 0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    chk(done == 1'b1, "R10 done seen", 64'(done), 64'd1);
    chk(busy == 1'b0, "R10 idle with done", 64'(busy), 64'd0);
    chk(rd_valid == !wr, "R10 rd_valid only for reads", 64'(rd_valid), 64'(!wr));
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", 64'(done), 64'd0);
    repeat (3 * eff + 4) @(negedge clk);
    chk(rise_k == 64, "R2 rising edges per frame", 64'(rise_k), 64'd64);
    chk(busy == 1'b0, "R9 no second frame", 64'(busy), 64'd0);
    chk(mdc == 1'b0 && mdio_oe == 1'b0, "R12 bus quiet after frame",
        64'({mdc, mdio_oe}), 64'd0);
    chk(rise_cyc1 - rise_cyc0 == 2 * eff, "R2 mdc period",
        64'(rise_cyc1 - rise_cyc0), 64'(2 * eff));
    chk(cap_o[63:32] == 32'hFFFF_FFFF && cap_oe[63:32] == 32'hFFFF_FFFF,
        "R3 preamble", cap_o[63:32], 64'hFFFF_FFFF);
    chk(cap_o[31:28] == exp_f[31:28], "R4 start and opcode",
        64'(cap_o[31:28]), 64'(exp_f[31:28]));
    chk(cap_o[27:18] == exp_f[27:18], "R5 addresses",
        64'(cap_o[27:18]), 64'(exp_f[27:18]));
    chk(r8_bad == 0, "R8 line stable at rising mdc", 64'(r8_bad), 64'd0);
    if (wr) begin
      chk(cap_o[17:0] == exp_f[17:0], "R6 turnaround and data",
          64'(cap_o[17:0]), 64'(exp_f[17:0]));
      chk(cap_oe == exp_oe, "R6 enable whole frame", cap_oe, exp_oe);
      chk(rd_data == last_rd, "R11 write keeps rd_data",
          64'(rd_data), 64'(last_rd));
    end else begin
      chk(cap_oe == exp_oe, "R7 released from turnaround", cap_oe, exp_oe);
      chk(rd_data == data, "R7 read word", 64'(rd_data), 64'(data));
      last_rd = data;
    end
  endtask

  initial begin
    #(200000 * 20);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0 && req_ready == 1'b1,
        "R1 reset state", 64'({mdc, mdio_oe, busy, req_ready}), 64'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mdc == 1'b0 && mdio_oe == 1'b0 && busy == 1'b0 && req_ready == 1'b1,
        "R1 idle after reset", 64'({mdc, mdio_oe, busy, req_ready}), 64'd1);
    chk(rd_data == 16'h0 && done == 1'b0, "R11 rd_data at reset",
        64'({done, rd_data}), 64'd0);

    for (int i = 0; i < 6; i++) begin
      run_txn(VEC[i][30], VEC[i][29:25], VEC[i][24:20], VEC[i][19:4],
              VEC[i][3:0], 1'b0);
    end

    // R9: intruding request during a read frame
    run_txn(1'b0, 5'h03, 5'h04, 16'h1234, 4'd2, 1'b1);
    // R9: intruding request during a write frame
    run_txn(1'b1, 5'h12, 5'h09, 16'hC0DE, 4'd1, 1'b1);
    // R11: read word still held after that write
    chk(rd_data == 16'h1234, "R11 held across writes", 64'(rd_data), 64'h1234);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule